// File: doc/BRIEF.md
# Slot-Based Interrupt Router

This block takes interrupt pin requests from the devices on a PCI bus and turns them into one interrupt line to the CPU. Each request names a bus slot, the pin on that slot (INTA to INTD, encoded 0 to 3) and the new level of that pin. A fixed, slot-dependent decode places the request on one of 32 internal lines, and the block keeps the current level of every line.

Software sets up each line through small registers. A trigger-mode mask selects pulse (edge) or level behaviour. A polarity mask gives the active level for level lines. An enable mask is changed only through separate set and clear write addresses. A steering word is stored and read back. The CPU output is a one-cycle pulse for an enabled edge line that goes from low to high, and otherwise a level for any enabled level line that sits at its active level.

Top module: `slot_irq_router`

## Requirements
- R1: A request from slot 5 with pin p (0..3) updates internal line p.
- R2: A request from slot 6 updates line 4 and a request from slot 7 updates line 5, whatever the pin.
- R3: A request from slot s in 8..12 with pin p updates line (s - 8 + p) + 6.
- R4: A request from any slot outside 5..12 changes no line and does not affect the CPU output.
- R5: For an enabled line whose bit is 1 in the trigger-mode register (address 0), a request that takes the line from 0 to 1 drives cpu_irq high for exactly one cycle. A request that leaves the line at 1 gives no pulse.
- R6: For an enabled line whose trigger-mode bit is 0, the line is active when its level equals its bit in the polarity register (address 2). cpu_irq is high while any such line is active.
- R7: A write to address 3 stores the written word, which reads back at address 3, and ORs it into the enable mask.
- R8: A write to address 4 stores the written word, which reads back at address 4, and clears the written bits in the enable mask.
- R9: The enable mask (address 5) and the line status (address 6) are read-only. Writes to them change nothing.
- R10: A line whose enable bit is 0 has no effect on cpu_irq.
- R11: The status register (address 6) shows the raw level of every line, whatever its enable bit.
- R12: After reset the trigger-mode, steering, enable, set-record and clear-record registers and all lines are 0, the polarity register is all ones, and cpu_irq is low.
- R13: The steering register (address 1) stores the written word and reads it back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A pin request is present this cycle |
| req_slot | input | 5 | Bus slot of the requesting device |
| req_pin | input | 2 | Interrupt pin on the slot, 0 to 3 for INTA to INTD |
| req_level | input | 1 | New level of that pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data, combinational from rd_addr |
| cpu_irq | output | 1 | Interrupt to the CPU |

## Verification
A request or register write that is sampled at one clock edge shows up in rd_data and cpu_irq right after that same edge. This is one register stage, and it holds for the edge pulse, which then falls after the next edge. The bench changes its inputs on the falling edge. It checks outputs on the next falling edge, with one rising edge in between. It checks the pulse a second time one cycle later to show that it lasts one cycle. Reads are combinational, so they are sampled a short delay after rd_addr changes, within the same low phase.

// File: rtl/slot_irq_router.sv
module slot_irq_router #(
  parameter int LINES  = 32,
  parameter int SLOT_W = 5,
  parameter int PIN_W  = 2,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [PIN_W-1:0]  req_pin,
  input  logic              req_level,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LINES-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [LINES-1:0]  rd_data,
  output logic              cpu_irq
);
  localparam int LINE_W = $clog2(LINES);
  localparam logic [ADDR_W-1:0] A_EDGE  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STEER = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(6);

  logic [LINES-1:0]  edge_cfg, steer_cfg, pol_cfg, set_rec, clr_rec, en_mask, line_lvl;
  logic              pulse_q, map_ok, edge_hit;
  logic [LINE_W-1:0] map_line;

  always_comb begin
    map_ok   = 1'b1;
    map_line = '0;
    if (req_slot == SLOT_W'(5))
      map_line = LINE_W'(req_pin);
    else if (req_slot == SLOT_W'(6))
      map_line = LINE_W'(4);
    else if (req_slot == SLOT_W'(7))
      map_line = LINE_W'(5);
    else if (req_slot >= SLOT_W'(8) && req_slot <= SLOT_W'(12))
      map_line = LINE_W'(req_slot - SLOT_W'(8)) + LINE_W'(req_pin) + LINE_W'(6);
    else
      map_ok = 1'b0;
  end

  assign edge_hit = req_valid & map_ok & req_level & ~line_lvl[map_line]
                  & edge_cfg[map_line] & en_mask[map_line];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_cfg  <= '0;
      steer_cfg <= '0;
      pol_cfg   <= '1;
      set_rec   <= '0;
      clr_rec   <= '0;
      en_mask   <= '0;
      line_lvl  <= '0;
      pulse_q   <= 1'b0;
    end else begin
      pulse_q <= edge_hit;
      if (req_valid && map_ok)
        line_lvl[map_line] <= req_level;
      if (wr_en) begin
        case (wr_addr)
          A_EDGE:  edge_cfg  <= wr_data;
          A_STEER: steer_cfg <= wr_data;
          A_POL:   pol_cfg   <= wr_data;
          A_SET: begin
            set_rec <= wr_data;
            en_mask <= en_mask | wr_data;
          end
          A_CLR: begin
            clr_rec <= wr_data;
            en_mask <= en_mask & ~wr_data;
          end
          default: ;
        endcase
      end
    end
  end

  assign cpu_irq = pulse_q | (|(en_mask & ~edge_cfg & ~(line_lvl ^ pol_cfg)));

  always_comb begin
    case (rd_addr)
      A_EDGE:  rd_data = edge_cfg;
      A_STEER: rd_data = steer_cfg;
      A_POL:   rd_data = pol_cfg;
      A_SET:   rd_data = set_rec;
      A_CLR:   rd_data = clr_rec;
      A_EN:    rd_data = en_mask;
      A_STAT:  rd_data = line_lvl;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/slot_irq_router_chk.sv
module slot_irq_router_chk #(
  parameter int LINES  = 32,
  parameter int SLOT_W = 5,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [SLOT_W-1:0] req_slot,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [LINES-1:0]  wr_data,
  input logic [LINES-1:0]  en_mask,
  input logic [LINES-1:0]  line_lvl,
  input logic              cpu_irq
);
  p_unmapped_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_slot < SLOT_W'(5) || req_slot > SLOT_W'(12))) |=> $stable(line_lvl));

  p_set_ors_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(3)) |=> ((en_mask & $past(wr_data)) == $past(wr_data)));

  p_clr_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(4)) |=> ((en_mask & $past(wr_data)) == '0));

  p_en_readonly_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && (wr_addr == ADDR_W'(3) || wr_addr == ADDR_W'(4)))) |=> $stable(en_mask));

  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_mask == '0 && $past(en_mask) == '0) |-> !cpu_irq);
endmodule

bind slot_irq_router slot_irq_router_chk #(
  .LINES(LINES), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_slot(req_slot),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .en_mask(en_mask), .line_lvl(line_lvl), .cpu_irq(cpu_irq)
);

// File: tb/slot_irq_router_bench.sv
module slot_irq_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [4:0]  req_slot = '0;
  logic [1:0]  req_pin = '0;
  logic        req_level = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        cpu_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  slot_irq_router u_slot_irq_router (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_slot(req_slot),
    .req_pin(req_pin), .req_level(req_level), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cpu_irq(cpu_irq)
  );

  // {slot[12:8], pin[7:6], mapped[5], line[4:0]}
  localparam int NV = 12;
  localparam logic [12:0] VEC [NV] = '{
    {5'd5,  2'd0, 1'b1, 5'd0},  {5'd5,  2'd1, 1'b1, 5'd1},
    {5'd5,  2'd2, 1'b1, 5'd2},  {5'd5,  2'd3, 1'b1, 5'd3},
    {5'd6,  2'd2, 1'b1, 5'd4},  {5'd7,  2'd0, 1'b1, 5'd5},
    {5'd8,  2'd0, 1'b1, 5'd6},  {5'd8,  2'd3, 1'b1, 5'd9},
    {5'd10, 2'd1, 1'b1, 5'd9},  {5'd12, 2'd3, 1'b1, 5'd13},
    {5'd4,  2'd0, 1'b0, 5'd0},  {5'd13, 2'd1, 1'b0, 5'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic req(input logic [4:0] s, input logic [1:0] p, input logic l);
    @(negedge clk);
    req_valid = 1'b1; req_slot = s; req_pin = p; req_level = l;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    rd(3'd0, d); chk("R12 edge reset", d, 32'h0);
    rd(3'd1, d); chk("R12 steer reset", d, 32'h0);
    rd(3'd2, d); chk("R12 pol reset", d, 32'hFFFF_FFFF);
    rd(3'd3, d); chk("R12 setrec reset", d, 32'h0);
    rd(3'd4, d); chk("R12 clrrec reset", d, 32'h0);
    rd(3'd5, d); chk("R12 en reset", d, 32'h0);
    rd(3'd6, d); chk("R12 status reset", d, 32'h0);
    chk("R12 irq reset", {31'b0, cpu_irq}, 32'h0);

    // R7 enable all lines
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd5, d); chk("R7 en after set", d, 32'hFFFF_FFFF);
    rd(3'd3, d); chk("R7 set record", d, 32'hFFFF_FFFF);

    // R1 R2 R3 R4 mapping table
    for (int i = 0; i < NV; i++) begin
      logic [31:0] exp;
      exp = VEC[i][5] ? (32'h1 << VEC[i][4:0]) : 32'h0;
      req(VEC[i][12:8], VEC[i][7:6], 1'b1);
      rd(3'd6, d); chk($sformatf("R1/R2/R3/R4 status vec %0d", i), d, exp);
      chk($sformatf("R4/R6 irq vec %0d", i), {31'b0, cpu_irq}, {31'b0, VEC[i][5]});
      req(VEC[i][12:8], VEC[i][7:6], 1'b0);
      rd(3'd6, d); chk($sformatf("R11 status cleared vec %0d", i), d, 32'h0);
    end

    // R8 clear port, R7 OR semantics
    wr(3'd4, 32'h0000_00F0);
    rd(3'd5, d); chk("R8 en after clear", d, 32'hFFFF_FF0F);
    rd(3'd4, d); chk("R8 clear record", d, 32'h0000_00F0);
    wr(3'd3, 32'h0000_0030);
    rd(3'd5, d); chk("R7 en after or", d, 32'hFFFF_FF3F);
    rd(3'd3, d); chk("R7 set record 2", d, 32'h0000_0030);

    // R9 read-only registers
    wr(3'd5, 32'h0);
    rd(3'd5, d); chk("R9 en write ignored", d, 32'hFFFF_FF3F);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, d); chk("R9 status write ignored", d, 32'h0);

    // R13 steering
    wr(3'd1, 32'hA5A5_0001);
    rd(3'd1, d); chk("R13 steer readback", d, 32'hA5A5_0001);

    // R10 masking, R11 raw status
    wr(3'd4, 32'h0000_0010);
    req(5'd6, 2'd0, 1'b1);
    rd(3'd6, d); chk("R11 raw status masked line", d, 32'h0000_0010);
    chk("R10 masked line no irq", {31'b0, cpu_irq}, 32'h0);
    req(5'd6, 2'd0, 1'b0);

    // R5 edge pulse
    wr(3'd3, 32'h0000_0010);
    wr(3'd0, 32'h0000_0010);
    req(5'd6, 2'd1, 1'b1);
    chk("R5 pulse high", {31'b0, cpu_irq}, 32'h1);
    @(negedge clk);
    chk("R5 pulse one cycle", {31'b0, cpu_irq}, 32'h0);
    req(5'd6, 2'd1, 1'b1);
    chk("R5 no pulse without rise", {31'b0, cpu_irq}, 32'h0);
    req(5'd6, 2'd1, 1'b0);
    chk("R5 no pulse on fall", {31'b0, cpu_irq}, 32'h0);
    req(5'd6, 2'd3, 1'b1);
    chk("R5 pulse again", {31'b0, cpu_irq}, 32'h1);
    req(5'd6, 2'd3, 1'b0);

    // R6 polarity on level line 5
    wr(3'd2, 32'hFFFF_FFDF);
    chk("R6 active-low idle raises", {31'b0, cpu_irq}, 32'h1);
    req(5'd7, 2'd2, 1'b1);
    chk("R6 active-low asserted lowers", {31'b0, cpu_irq}, 32'h0);
    wr(3'd2, 32'hFFFF_FFFF);
    chk("R6 active-high asserted raises", {31'b0, cpu_irq}, 32'h1);
    req(5'd7, 2'd2, 1'b0);
    chk("R6 active-high idle lowers", {31'b0, cpu_irq}, 32'h0);

    finish_run();
  end
endmodule